// File: doc/BRIEF.md
# Single-Segment Memory Transfer Engine for a Card Host

This engine moves one contiguous buffer between system memory and the data queue of a card host controller. Software programs a transfer mode (direction, beat width, address stepping), a 64-bit buffer address written as two 32-bit halves, and then writes a self-clearing go bit. The engine issues one memory beat at a time on a plain request/acknowledge interface and reports the end of the transfer with a one-cycle completion pulse.

Each direction has its own channel run bit. Clearing the bit of the running channel abandons the transfer at once, and the host uses this to abort. A parameter removes the device-to-memory direction, which leaves an engine that can only transmit. Starts that cannot be carried out do not hang the host. A start with a misaligned buffer, an undefined direction code or a disabled direction finishes at once with an error flag.

Top module: `sd_seg_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `done` and `err` are low, and both channel run bits are set.
- R2: Direction code 0 (mode bits [17:16] = 0) reads memory. Every accepted beat has `mem_we` low and forwards `mem_rdata` to `dev_wdata` with a `dev_push` pulse in the same cycle.
- R3: Direction code 1 writes memory. Every accepted beat has `mem_we` high, drives `dev_rdata` onto `mem_wdata` and pulses `dev_pop` in the same cycle.
- R4: Mode bits [5:4] select the beat size of 1, 2, 4 or 8 bytes for codes 0 to 3. `mem_size` carries the code, and a transfer of L bytes (L > 0) takes ceil(L / size) accepted beats.
- R5: When mode bit 0 is set, the address of beat k is the start address plus k times the beat size. When it is clear, every beat uses the start address. A waiting request holds its address.
- R6: The start address is the word at offset 0x20 (bits 31:0) joined with the word at 0x24 (bits 63:32). A start whose address has any of bits [2:0] set issues no beat and finishes with `done` and `err`.
- R7: `done` rises for exactly one cycle, in the cycle after the final beat is accepted, and `busy` and `mem_req` are low in that cycle.
- R8: Writing 1 to bit 0 at offset 0x04 starts exactly one transfer. A go write while busy is ignored. Mode and address writes made while busy do not alter the running transfer.
- R9: Offset 0x08 bit 8 is the run bit of the memory-read channel and bit 9 is the run bit of the memory-write channel. Clearing the run bit of the active channel returns the engine to idle with no `done`. A start on a channel whose run bit is clear is ignored. Clearing the other channel's bit has no effect on the transfer.
- R10: A direction code of 2 or 3, or code 1 when `RX_EN` is 0, issues no beat and finishes with `done` and `err` high together. `err` is never high without `done`.
- R11: A start with `xfer_len` equal to 0 issues no beat and finishes with `done` and no `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| xfer_len | input | LEN_W | Transfer length in bytes, sampled at start |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a memory write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_size | output | 2 | Beat size code (bytes = 1 << code) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Beat accepted |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| dev_push | output | 1 | Write strobe into the device queue |
| dev_wdata | output | DATA_W | Data into the device queue |
| dev_pop | output | 1 | Read strobe from the device queue |
| dev_rdata | input | DATA_W | Data from the device queue |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Start was rejected (valid with `done`) |

## Verification
Three situations are hard to reach from the ports: a go write or a reprogramming write that lands while a transfer is running, a channel abort in the middle of a transfer, and a start on a held channel. The acknowledge is held low on purpose, so the engine sits with a request outstanding while these writes are applied. The acknowledge is then released and the bench counts the beats and checks their addresses against the original programming. Random transfers with random acknowledge gaps cover every width, both directions, both stepping modes and lengths that are not a multiple of the beat. A second instance built without the receive direction takes the same stimulus, so its immediate error finish can be compared against the full engine.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;

   localparam int REG_AW = 6;

   // register byte offsets
   localparam logic [REG_AW-1:0] RA_MODE    = 6'h00;
   localparam logic [REG_AW-1:0] RA_CTRL    = 6'h04;
   localparam logic [REG_AW-1:0] RA_CHRST   = 6'h08;
   localparam logic [REG_AW-1:0] RA_ADDR_LO = 6'h20;
   localparam logic [REG_AW-1:0] RA_ADDR_HI = 6'h24;

   // field positions decoded by software
   localparam int MODE_DIR_LSB = 16;
   localparam int MODE_WID_LSB = 4;
   localparam int MODE_INC_BIT = 0;
   localparam int CTRL_GO_BIT  = 0;
   localparam int RUN_TX_BIT   = 8;
   localparam int RUN_RX_BIT   = 9;

   localparam logic [1:0] DIR_TO_DEV   = 2'd0;
   localparam logic [1:0] DIR_FROM_DEV = 2'd1;

   typedef struct packed {
      logic [1:0] dir;
      logic [1:0] wcode;
      logic       inc;
   } xfer_mode_t;

   typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

endpackage

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output xfer_mode_t        mode,
   output logic [ADDR_W-1:0] base_addr,
   output logic              go,
   output logic [1:0]        ch_run
);

   localparam int HI_W = ADDR_W - 32;

   generate
      if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr_w
         $error("sd_dma_regs: ADDR_W must lie in 33..64");
      end
   endgenerate

   logic [31:0]     lo_q;
   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         go     <= 1'b0;
         ch_run <= 2'b11;
      end else begin
         go <= 1'b0;
         if (reg_wr) begin
            case (reg_addr)
               RA_MODE: begin
                  mode.dir   <= reg_wdata[MODE_DIR_LSB +: 2];
                  mode.wcode <= reg_wdata[MODE_WID_LSB +: 2];
                  mode.inc   <= reg_wdata[MODE_INC_BIT];
               end
               RA_CTRL:    go     <= reg_wdata[CTRL_GO_BIT];
               RA_CHRST:   ch_run <= {reg_wdata[RUN_RX_BIT], reg_wdata[RUN_TX_BIT]};
               RA_ADDR_LO: lo_q   <= reg_wdata;
               RA_ADDR_HI: hi_q   <= reg_wdata[HI_W-1:0];
               default: ;
            endcase
         end
      end
   end

   assign base_addr = {hi_q, lo_q};

endmodule

// File: rtl/sd_dma_admit.sv
module sd_dma_admit
   import sd_dma_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter bit RX_EN = 1'b1
) (
   input  logic             go,
   input  logic             busy,
   input  xfer_mode_t       mode,
   input  logic [2:0]       base_lsb,
   input  logic [LEN_W-1:0] len,
   input  logic [1:0]       ch_run,
   output logic             launch,
   output logic             finish,
   output logic             fail
);

   logic rx_ok;

   generate
      if (RX_EN) begin : g_rx_on
         assign rx_ok = 1'b1;
      end else begin : g_rx_off
         assign rx_ok = 1'b0;
      end
   endgenerate

   logic dir_known, dir_allowed, ch_held, misaligned, take;

   always_comb begin
      dir_known   = (mode.dir == DIR_TO_DEV) || (mode.dir == DIR_FROM_DEV);
      dir_allowed = (mode.dir == DIR_TO_DEV) || ((mode.dir == DIR_FROM_DEV) && rx_ok);
      ch_held     = dir_known && !ch_run[mode.dir[0]];
      misaligned  = (base_lsb != 3'b000);
      take        = go && !busy && !ch_held;
      fail        = take && (!dir_allowed || misaligned);
      launch      = take && !fail && (len != '0);
      finish      = take && (fail || (len == '0));
   end

endmodule

// File: rtl/sd_dma_engine.sv
module sd_dma_engine
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              finish,
   input  logic              fail,
   input  xfer_mode_t        mode,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [1:0]        ch_run,
   input  logic              mem_ack,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic              mem_we,
   output logic              done,
   output logic              err
);

   eng_state_e        state;
   xfer_mode_t        mode_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  rem;

   logic [LEN_W-1:0]  step_len;
   logic [ADDR_W-1:0] step_addr;
   logic              last_beat, abort;

   always_comb begin
      step_len  = LEN_W'(1) << mode_q.wcode;
      step_addr = ADDR_W'(1) << mode_q.wcode;
      last_beat = (rem <= step_len);
      abort     = (state == ENG_RUN) && !ch_run[mode_q.dir[0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         mode_q   <= '0;
         cur_addr <= '0;
         rem      <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            ENG_IDLE: begin
               if (launch) begin
                  state    <= ENG_RUN;
                  mode_q   <= mode;
                  cur_addr <= base_addr;
                  rem      <= len;
               end else if (finish) begin
                  done <= 1'b1;
                  err  <= fail;
               end
            end
            ENG_RUN: begin
               if (abort) begin
                  state <= ENG_IDLE;
               end else if (mem_ack) begin
                  if (last_beat) begin
                     state <= ENG_IDLE;
                     done  <= 1'b1;
                  end else begin
                     rem <= rem - step_len;
                     if (mode_q.inc) cur_addr <= cur_addr + step_addr;
                  end
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   assign busy     = (state == ENG_RUN);
   assign mem_addr = cur_addr;
   assign mem_size = mode_q.wcode;
   assign mem_we   = mode_q.dir[0];

endmodule

// File: rtl/sd_seg_dma.sv
module sd_seg_dma
   import sd_dma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int LEN_W  = 16,
   parameter bit RX_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              dev_push,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              dev_pop,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              busy,
   output logic              done,
   output logic              err
);

   generate
      if (DATA_W < 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("sd_seg_dma: DATA_W must be a power of two of at least 64");
      end
      if (LEN_W < 4) begin : g_bad_len_w
         $error("sd_seg_dma: LEN_W must be at least 4");
      end
   endgenerate

   xfer_mode_t        mode;
   logic [ADDR_W-1:0] base_addr;
   logic              go, launch, finish, fail;
   logic [1:0]        ch_run;

   sd_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .mode     (mode),
      .base_addr(base_addr),
      .go       (go),
      .ch_run   (ch_run)
   );

   sd_dma_admit #(.LEN_W(LEN_W), .RX_EN(RX_EN)) u_admit (
      .go      (go),
      .busy    (busy),
      .mode    (mode),
      .base_lsb(base_addr[2:0]),
      .len     (xfer_len),
      .ch_run  (ch_run),
      .launch  (launch),
      .finish  (finish),
      .fail    (fail)
   );

   sd_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .finish   (finish),
      .fail     (fail),
      .mode     (mode),
      .base_addr(base_addr),
      .len      (xfer_len),
      .ch_run   (ch_run),
      .mem_ack  (mem_ack),
      .busy     (busy),
      .mem_addr (mem_addr),
      .mem_size (mem_size),
      .mem_we   (mem_we),
      .done     (done),
      .err      (err)
   );

   assign mem_req   = busy;
   assign dev_push  = mem_req & mem_ack & ~mem_we;
   assign dev_pop   = mem_req & mem_ack & mem_we;
   assign dev_wdata = mem_rdata;
   assign mem_wdata = dev_rdata;

endmodule

// File: rtl/sd_seg_dma_chk.sv
module sd_seg_dma_chk #(
   parameter int ADDR_W = 64,
   parameter bit RX_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [1:0]        mem_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              dev_push,
   input logic              dev_pop
);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !mem_req));

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R2
   push_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_push |-> (mem_ack && !mem_we));

   // R3
   pop_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_pop |-> (mem_ack && mem_we));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

   // R6
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr[2:0] & ((3'd1 << mem_size) - 3'd1)) == 3'd0));

   generate
      if (!RX_EN) begin : g_tx_only
         // R10
         rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> !mem_we);
      end
   endgenerate

endmodule

bind sd_seg_dma sd_seg_dma_chk #(.ADDR_W(ADDR_W), .RX_EN(RX_EN)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .mem_req (mem_req),
   .mem_ack (mem_ack),
   .mem_we  (mem_we),
   .mem_size(mem_size),
   .mem_addr(mem_addr),
   .dev_push(dev_push),
   .dev_pop (dev_pop)
);

// File: tb/tb_sd_seg_dma.sv
module tb_sd_seg_dma;
   import sd_dma_pkg::*;

   localparam int ADDR_W = 64;
   localparam int DATA_W = 64;
   localparam int LEN_W  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              reg_wr = 1'b0;
   logic [REG_AW-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [LEN_W-1:0]  xfer_len = '0;
   logic              mem_ack = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic [DATA_W-1:0] dev_rdata = '0;

   logic              mem_req, mem_we, dev_push, dev_pop, busy, done, err;
   logic [ADDR_W-1:0] mem_addr;
   logic [1:0]        mem_size;
   logic [DATA_W-1:0] mem_wdata, dev_wdata;

   logic              t_req, t_we, t_push, t_pop, t_busy, t_done, t_err;
   logic [ADDR_W-1:0] t_addr;
   logic [1:0]        t_size;
   logic [DATA_W-1:0] t_wdata, t_dwdata;

   sd_seg_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RX_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .xfer_len(xfer_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .dev_push(dev_push), .dev_wdata(dev_wdata), .dev_pop(dev_pop), .dev_rdata(dev_rdata),
      .busy(busy), .done(done), .err(err));

   sd_seg_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .RX_EN(1'b0)) dut_tx (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .xfer_len(xfer_len), .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr),
      .mem_size(t_size), .mem_wdata(t_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .dev_push(t_push), .dev_wdata(t_dwdata), .dev_pop(t_pop), .dev_rdata(dev_rdata),
      .busy(t_busy), .done(t_done), .err(t_err));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expectation set by the stimulus, read by the monitor
   int          ack_mode = 0;
   logic [63:0] exp_base = '0;
   logic [1:0]  exp_size = '0;
   bit          exp_we = 1'b0;
   bit          exp_inc = 1'b0;
   int          beat_base = 0;

   // written only by the monitors
   int   beats = 0;
   int   done_cnt = 0;
   int   tx_done_cnt = 0;
   logic tx_err_last = 1'b0;
   logic err_at_done = 1'b0;

   function automatic int n_beats(input int len, input int w);
      return (len == 0) ? 0 : (len + (1 << w) - 1) >> w;
   endfunction

   always @(negedge clk) begin
      case (ack_mode)
         0: mem_ack = 1'b0;
         1: mem_ack = 1'b1;
         default: mem_ack = $urandom_range(0, 1) == 1;
      endcase
      dev_rdata = {$urandom, $urandom};
      mem_rdata = {32'hC0DE0000 + beats, $urandom};
      #1;
      if (mem_req && mem_ack) begin
         logic [63:0] ea;
         ea = exp_inc ? exp_base + (64'(beats - beat_base) << exp_size) : exp_base;
         chk(mem_addr == ea, "R5 beat address", mem_addr, ea);
         chk(mem_size == exp_size, "R4 beat size code", 64'(mem_size), 64'(exp_size));
         if (exp_we) begin
            chk(mem_we && dev_pop && !dev_push, "R3 write beat strobes",
                {mem_we, dev_pop, dev_push}, 3'b110);
            chk(mem_wdata == dev_rdata, "R3 write data", mem_wdata, dev_rdata);
         end else begin
            chk(!mem_we && dev_push && !dev_pop, "R2 read beat strobes",
                {mem_we, dev_pop, dev_push}, 3'b001);
            chk(dev_wdata == mem_rdata, "R2 forwarded data", dev_wdata, mem_rdata);
         end
         beats++;
      end
   end

   always @(negedge clk) begin
      #2;
      if (done) begin
         done_cnt++;
         err_at_done = err;
      end
      if (t_done) begin
         tx_done_cnt++;
         tx_err_last = t_err;
      end
   end

   task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   int db, tb0;

   task automatic launch(input logic [1:0] dir, input logic [1:0] w, input bit inc,
                         input logic [63:0] a, input int len);
      exp_base = a; exp_size = w; exp_we = dir[0]; exp_inc = inc;
      beat_base = beats; db = done_cnt; tb0 = tx_done_cnt;
      xfer_len = LEN_W'(len);
      wr(RA_MODE, (32'(dir) << MODE_DIR_LSB) | (32'(w) << MODE_WID_LSB) | 32'(inc));
      wr(RA_ADDR_LO, a[31:0]);
      wr(RA_ADDR_HI, a[63:32]);
      wr(RA_CTRL, 32'h1);
   endtask

   task automatic finish_xfer(input bit exp_err, input int exp_n, input bit tx_exp_err, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 4000 && !seen; i++) begin
         @(negedge clk); #3;
         if (done_cnt != db) seen = 1'b1;
      end
      chk(seen && done_cnt == db + 1, {req, " R7 single done"}, 64'(done_cnt - db), 64'd1);
      chk(err_at_done == exp_err, {req, " R10 err flag"}, 64'(err_at_done), 64'(exp_err));
      chk(beats - beat_base == exp_n, {req, " R4 beat count"}, 64'(beats - beat_base), 64'(exp_n));
      chk(tx_done_cnt != tb0 && tx_err_last == tx_exp_err, {req, " R10 tx-only instance"},
          64'(tx_err_last), 64'(tx_exp_err));
      @(negedge clk); #3;
      chk(!done && !busy && !mem_req, {req, " R7 idle after done"}, {done, busy, mem_req}, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      #1;
      @(posedge clk); #2;
      // R1
      chk(!busy && !mem_req && !done && !err, "R1 reset state", {busy, mem_req, done, err}, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 and R4: read with stepping, running channels after reset (R1)
      ack_mode = 1;
      launch(2'd0, 2'd3, 1'b1, 64'h0000_0001_0000_1000, 32);
      finish_xfer(1'b0, 4, 1'b0, "R1 R2 dir0 8-byte");

      // R3 with partial final beat
      ack_mode = 2;
      launch(2'd1, 2'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, 13);
      finish_xfer(1'b0, 4, 1'b1, "R3 dir1 4-byte");

      // R5 fixed address
      launch(2'd0, 2'd1, 1'b0, 64'h0000_0000_0000_0040, 10);
      finish_xfer(1'b0, 5, 1'b0, "R5 fixed address");

      // R11 zero length
      launch(2'd0, 2'd0, 1'b1, 64'h0000_0000_0000_0080, 0);
      finish_xfer(1'b0, 0, 1'b0, "R11 zero length");

      // R6 misaligned start address
      launch(2'd0, 2'd3, 1'b1, 64'h0000_0000_0000_0103, 16);
      finish_xfer(1'b1, 0, 1'b1, "R6 misaligned");

      // R10 undefined direction code
      launch(2'd2, 2'd3, 1'b1, 64'h0000_0000_0000_0200, 16);
      finish_xfer(1'b1, 0, 1'b1, "R10 dir code 2");

      // R8 go and reprogramming while busy are ignored
      ack_mode = 0;
      launch(2'd0, 2'd3, 1'b1, 64'h0000_00AB_0000_0800, 32);
      repeat (4) @(negedge clk);
      #3 chk(busy && mem_req, "R8 busy while stalled", {busy, mem_req}, 2'b11);
      wr(RA_MODE, 32'h0001_0000);
      wr(RA_ADDR_LO, 32'h0000_1004);
      wr(RA_CTRL, 32'h1);
      repeat (3) @(negedge clk);
      #3 chk(busy && done_cnt == db, "R8 second go ignored", 64'(done_cnt - db), 64'd0);
      ack_mode = 1;
      finish_xfer(1'b0, 4, 1'b0, "R8 original transfer");

      // R9 abort through the channel run bit
      ack_mode = 0;
      launch(2'd0, 2'd2, 1'b1, 64'h0000_0000_0000_3000, 64);
      repeat (4) @(negedge clk);
      wr(RA_CHRST, 32'h0000_0200);
      repeat (3) @(negedge clk);
      #3 chk(!busy && !mem_req, "R9 abort to idle", {busy, mem_req}, 0);
      chk(done_cnt == db, "R9 no done after abort", 64'(done_cnt - db), 64'd0);
      // R9 start on a held channel is ignored
      ack_mode = 1;
      launch(2'd0, 2'd2, 1'b1, 64'h0000_0000_0000_3000, 8);
      repeat (10) @(negedge clk);
      #3 chk(!busy && done_cnt == db && beats == beat_base, "R9 held channel start ignored",
             64'(beats - beat_base), 64'd0);
      // R9 holding the other channel leaves a read transfer alone
      wr(RA_CHRST, 32'h0000_0100);
      launch(2'd0, 2'd0, 1'b1, 64'h0000_0000_0000_3000, 5);
      finish_xfer(1'b0, 5, 1'b0, "R9 other channel held");
      wr(RA_CHRST, 32'h0000_0300);

      // random transfers
      ack_mode = 2;
      for (int n = 0; n < 40; n++) begin
         logic [1:0]  d, w;
         bit          inc;
         logic [63:0] a;
         int          len;
         d   = 2'($urandom_range(0, 1));
         w   = 2'($urandom_range(0, 3));
         inc = $urandom_range(0, 1) == 1;
         a   = {$urandom, $urandom} & ~64'h7;
         len = $urandom_range(0, 64);
         launch(d, w, inc, a, len);
         finish_xfer(1'b0, n_beats(len, int'(w)), d[0], "R2 R3 R4 R5 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule